// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vector-load command into a sequence of single-element memory read requests. A command carries a scalar base address, an element size, a stride value, a per-lane table of offsets, an element count, a field count for segment loads, a destination register number and a predicate mask with an enable and an invert bit. Once the command is accepted, the block sends one request per cycle over a valid/ready channel. Each request carries the byte address to read, the register that receives the data and the element slot within that register.

Three addressing schemes are supported. In unit-stride loads the element size is the step. In constant-stride loads the stride value is the step. In indexed loads each element's offset is taken from its own lane of the offset table, and the step still spaces the fields of a segment. Elements that the predicate turns off produce no traffic at all. A one-cycle completion pulse tells the issuing pipeline that the whole command has been sent. Data return, alignment and the memory itself belong to other blocks.

Top module: `vld_addr_gen`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress, and a command presented while `cmd_ready` is low is ignored: it neither changes the request stream in progress nor starts a later one.
- R2: With `cmd_strided`=0 and `cmd_indexed`=0, the step is `cmd_esize` (bytes), and field j of element i is read at `cmd_base + i*(cmd_nf+1)*cmd_esize + j*cmd_esize`.
- R3: With `cmd_strided`=1 and `cmd_indexed`=0, the step is `cmd_stride`, and field j of element i is read at `cmd_base + i*(cmd_nf+1)*cmd_stride + j*cmd_stride`.
- R4: With `cmd_indexed`=1, element i's offset is lane i of `cmd_idx` (bits `[32*i+31:32*i]`), and field j is read at `cmd_base + lane_i + j*step`, where step follows `cmd_strided` as in R2/R3.
- R5: Field j of a segment targets register `(cmd_dest + j) mod 32`, and `req_elem` carries the element number i.
- R6: Element i is active when `cmd_pred_en`=0, or when `cmd_pred_mask[i] XOR cmd_pred_inv` = 1. An inactive element issues no request.
- R7: Only elements 0 to `cmd_len`-1 are visited. Requests go out in ascending element order, and within an element they go out for fields 0 to `cmd_nf` in order. Exactly one request is issued per active (element, field) pair.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_reg` and `req_elem` hold their values.
- R9: All address arithmetic is modulo 2^32.
- R10: `done` is high for exactly one cycle. It rises at the clock edge that accepts the final request. If a command has no active element, it rises at the second edge after the command is accepted. `cmd_ready` is high again in that same cycle.
- R11: Command fields are captured when the command is accepted, and later changes on the command inputs do not affect the request stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_base | input | ADDR_W | Scalar base address |
| cmd_esize | input | ESZ_W | Element size in bytes (unit-stride step) |
| cmd_stride | input | ADDR_W | Stride value for constant-stride step |
| cmd_strided | input | 1 | 1 selects `cmd_stride` as step, 0 selects `cmd_esize` |
| cmd_indexed | input | 1 | 1 takes element offsets from `cmd_idx` |
| cmd_idx | input | MAX_VL*ADDR_W | Per-element offset lanes, lane i at bits `[ADDR_W*i +: ADDR_W]` |
| cmd_nf | input | SEG_W | Fields per element minus one |
| cmd_len | input | clog2(MAX_VL+1) | Number of elements to visit |
| cmd_dest | input | REG_W | First destination register |
| cmd_pred_en | input | 1 | Predicate in use |
| cmd_pred_mask | input | MAX_VL | Predicate bits, bit i for element i |
| cmd_pred_inv | input | 1 | Invert predicate bits |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request taken this cycle if valid |
| req_addr | output | ADDR_W | Byte address to read |
| req_reg | output | REG_W | Destination register |
| req_elem | output | clog2(MAX_VL) | Element slot within the register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with MAX_VL=8, SEG_W=3 and the default 32-bit addresses. With these values a fully active command with eight fields per element produces the largest stream, 64 requests, and an eight-bit mask can be set to all-on and all-off. Destination numbering can be pushed across register 31, and a base near the top of the address space makes the modulo wrap reachable within two elements. Random back-pressure on `req_ready` exercises the hold behaviour and the done timing against every final handshake.

// File: rtl/vlg_pkg.sv
package vlg_pkg;

  // Sequencer phases: idle, first-element search, request issue.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_ISSUE = 2'd2
  } vlg_state_e;

endpackage : vlg_pkg

// File: rtl/vlg_pick.sv
// Finds the lowest active element whose number is not below 'from'.
module vlg_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  act,
  input  logic [IW:0]   from,
  output logic          found,
  output logic [IW-1:0] idx
);

  localparam int FW = IW + 1;

  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = act[g] && (from <= FW'(g));
  end

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[k]) idx = IW'(k);
    end
  end

  assign found = |elig;

endmodule : vlg_pick

// File: rtl/vlg_addr.sv
// Address datapath: captures the command operands and walks the address.
module vlg_addr #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 16,
  parameter int SEG_W  = 3,
  parameter int ESZ_W  = 4,
  parameter int EW     = $clog2(MAX_VL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [ESZ_W-1:0]         cmd_esize,
  input  logic [ADDR_W-1:0]        cmd_stride,
  input  logic                     cmd_strided,
  input  logic                     cmd_indexed,
  input  logic [MAX_VL*ADDR_W-1:0] cmd_idx,
  input  logic [SEG_W-1:0]         cmd_nf,
  input  logic                     load,
  input  logic                     step,
  input  logic [EW-1:0]            sel_elem,
  output logic [ADDR_W-1:0]        addr
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] segstep_q;
  logic              indexed_q;
  logic [ADDR_W-1:0] idx_q [MAX_VL];
  logic [ADDR_W-1:0] addr_q;

  logic [ADDR_W-1:0] step_in;
  logic [ADDR_W-1:0] segstep_in;
  logic [ADDR_W-1:0] elem_off;
  logic [ADDR_W-1:0] addr_d;

  // Operand capture (next-state side).
  always_comb begin
    step_in    = cmd_strided ? cmd_stride : ADDR_W'(cmd_esize);
    segstep_in = step_in * (ADDR_W'(cmd_nf) + ADDR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      step_q    <= '0;
      segstep_q <= '0;
      indexed_q <= 1'b0;
    end else if (take) begin
      base_q    <= cmd_base;
      step_q    <= step_in;
      segstep_q <= segstep_in;
      indexed_q <= cmd_indexed;
    end
  end

  for (genvar g = 0; g < MAX_VL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[g] <= '0;
      end else if (take) begin
        idx_q[g] <= cmd_idx[g*ADDR_W +: ADDR_W];
      end
    end
  end

  // Element start offset, then field walk by one step per accepted field.
  always_comb begin
    elem_off = indexed_q ? idx_q[sel_elem] : segstep_q * ADDR_W'(sel_elem);
    addr_d   = addr_q;
    if (load)      addr_d = base_q + elem_off;
    else if (step) addr_d = addr_q + step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R4: a load pulse picks up the captured lane of the selected element.
  a_r4_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && indexed_q) |=> (addr_q == $past(base_q) + $past(idx_q[sel_elem])));

endmodule : vlg_addr

// File: rtl/vlg_ctrl.sv
// Element/field sequencer with predicate capture and handshake control.
module vlg_ctrl
  import vlg_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  parameter int EW     = $clog2(MAX_VL),
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [SEG_W-1:0]  cmd_nf,
  input  logic [VLW-1:0]    cmd_len,
  input  logic [REG_W-1:0]  cmd_dest,
  input  logic              cmd_pred_en,
  input  logic [MAX_VL-1:0] cmd_pred_mask,
  input  logic              cmd_pred_inv,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [REG_W-1:0]  req_reg,
  output logic [EW-1:0]     req_elem,
  output logic              done,
  output logic              take,
  output logic              addr_load,
  output logic              addr_step,
  output logic [EW-1:0]     sel_elem
);

  localparam int FW = EW + 1;

  vlg_state_e        state_q, state_d;
  logic [EW-1:0]     elem_q, elem_d;
  logic [SEG_W-1:0]  field_q, field_d;
  logic              done_q, done_d;
  logic [MAX_VL-1:0] act_q;
  logic [SEG_W-1:0]  nf_q;
  logic [REG_W-1:0]  dest_q;

  logic [MAX_VL-1:0] in_len;
  logic [MAX_VL-1:0] pred_sel;
  logic [MAX_VL-1:0] act_d;
  logic [FW-1:0]     pick_from;
  logic              pick_found;
  logic [EW-1:0]     pick_idx;
  logic              fire;
  logic              last_field;

  // Active-element mask formed at command acceptance.
  for (genvar g = 0; g < MAX_VL; g++) begin : g_len
    assign in_len[g] = (VLW'(g) < cmd_len);
  end

  always_comb begin
    pred_sel = cmd_pred_en ? (cmd_pred_mask ^ {MAX_VL{cmd_pred_inv}}) : '1;
    act_d    = pred_sel & in_len;
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign take       = cmd_valid && cmd_ready;
  assign req_valid  = (state_q == ST_ISSUE);
  assign fire       = req_valid && req_ready;
  assign last_field = (field_q == nf_q);
  assign pick_from  = (state_q == ST_SEEK) ? '0 : ({1'b0, elem_q} + FW'(1));

  vlg_pick #(
    .N  (MAX_VL),
    .IW (EW)
  ) u_pick (
    .act   (act_q),
    .from  (pick_from),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    elem_d    = elem_q;
    field_d   = field_q;
    done_d    = 1'b0;
    addr_load = 1'b0;
    addr_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) state_d = ST_SEEK;
      end
      ST_SEEK: begin
        if (pick_found) begin
          state_d   = ST_ISSUE;
          elem_d    = pick_idx;
          field_d   = '0;
          addr_load = 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (fire) begin
          if (!last_field) begin
            field_d   = field_q + SEG_W'(1);
            addr_step = 1'b1;
          end else if (pick_found) begin
            elem_d    = pick_idx;
            field_d   = '0;
            addr_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Sequencer registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      field_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      field_q <= field_d;
      done_q  <= done_d;
    end
  end

  // Command capture registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      nf_q   <= '0;
      dest_q <= '0;
    end else if (take) begin
      act_q  <= act_d;
      nf_q   <= cmd_nf;
      dest_q <= cmd_dest;
    end
  end

  assign sel_elem = pick_idx;
  assign req_reg  = dest_q + REG_W'(field_q);
  assign req_elem = elem_q;
  assign done     = done_q;

  // R6: only elements left active by the predicate are presented.
  a_r6_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> act_q[elem_q]);

  // R7: moving off an element always lands on a higher element.
  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_field) |=> (!req_valid || (req_elem > $past(req_elem))));

  // R8: a stalled request keeps its destination fields.
  a_r8_hold_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_elem) && $stable(req_reg)));

  // R10: completion is a single-cycle pulse.
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: a command offered while busy leaves the captured predicate untouched.
  a_r1_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (state_q != ST_IDLE)) |=> $stable(act_q));

endmodule : vlg_ctrl

// File: rtl/vld_addr_gen.sv
// Vector load address sequencer: top level.
module vld_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 16,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  parameter int ESZ_W  = 4,
  localparam int EW    = $clog2(MAX_VL),
  localparam int VLW   = $clog2(MAX_VL + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [ESZ_W-1:0]         cmd_esize,
  input  logic [ADDR_W-1:0]        cmd_stride,
  input  logic                     cmd_strided,
  input  logic                     cmd_indexed,
  input  logic [MAX_VL*ADDR_W-1:0] cmd_idx,
  input  logic [SEG_W-1:0]         cmd_nf,
  input  logic [VLW-1:0]           cmd_len,
  input  logic [REG_W-1:0]         cmd_dest,
  input  logic                     cmd_pred_en,
  input  logic [MAX_VL-1:0]        cmd_pred_mask,
  input  logic                     cmd_pred_inv,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [REG_W-1:0]         req_reg,
  output logic [EW-1:0]            req_elem,
  output logic                     done
);

  logic          take;
  logic          addr_load;
  logic          addr_step;
  logic [EW-1:0] sel_elem;

  vlg_ctrl #(
    .MAX_VL (MAX_VL),
    .SEG_W  (SEG_W),
    .REG_W  (REG_W),
    .EW     (EW),
    .VLW    (VLW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_nf        (cmd_nf),
    .cmd_len       (cmd_len),
    .cmd_dest      (cmd_dest),
    .cmd_pred_en   (cmd_pred_en),
    .cmd_pred_mask (cmd_pred_mask),
    .cmd_pred_inv  (cmd_pred_inv),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_reg       (req_reg),
    .req_elem      (req_elem),
    .done          (done),
    .take          (take),
    .addr_load     (addr_load),
    .addr_step     (addr_step),
    .sel_elem      (sel_elem)
  );

  vlg_addr #(
    .ADDR_W (ADDR_W),
    .MAX_VL (MAX_VL),
    .SEG_W  (SEG_W),
    .ESZ_W  (ESZ_W),
    .EW     (EW)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .cmd_base    (cmd_base),
    .cmd_esize   (cmd_esize),
    .cmd_stride  (cmd_stride),
    .cmd_strided (cmd_strided),
    .cmd_indexed (cmd_indexed),
    .cmd_idx     (cmd_idx),
    .cmd_nf      (cmd_nf),
    .load        (addr_load),
    .step        (addr_step),
    .sel_elem    (sel_elem),
    .addr        (req_addr)
  );

  // R8: a stalled request keeps its address.
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R5: within one element, consecutive requests move to the next register.
  a_r5_reg_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!req_valid || (req_elem != $past(req_elem)) ||
       (req_reg == $past(req_reg) + REG_W'(1))));

  // R1: no request is presented while a new command can be taken.
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !req_valid);

endmodule : vld_addr_gen

// File: tb/vld_addr_gen_bench.sv
`timescale 1ns/1ps
module vld_addr_gen_bench;

  localparam int MV = 8;
  localparam int SW = 3;
  localparam int RW = 5;
  localparam int AW = 32;
  localparam int ZW = 4;
  localparam int EW = 3;
  localparam int VW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [AW-1:0]   cmd_base = '0;
  logic [ZW-1:0]   cmd_esize = '0;
  logic [AW-1:0]   cmd_stride = '0;
  logic            cmd_strided = 1'b0;
  logic            cmd_indexed = 1'b0;
  logic [MV*AW-1:0] cmd_idx = '0;
  logic [SW-1:0]   cmd_nf = '0;
  logic [VW-1:0]   cmd_len = '0;
  logic [RW-1:0]   cmd_dest = '0;
  logic            cmd_pred_en = 1'b0;
  logic [MV-1:0]   cmd_pred_mask = '0;
  logic            cmd_pred_inv = 1'b0;
  logic            req_valid;
  logic            req_ready = 1'b0;
  logic [AW-1:0]   req_addr;
  logic [RW-1:0]   req_reg;
  logic [EW-1:0]   req_elem;
  logic            done;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] e_addr [64];
  logic [RW-1:0] e_reg  [64];
  logic [EW-1:0] e_elem [64];
  int            e_n;

  always #2 clk = ~clk;

  vld_addr_gen #(
    .ADDR_W (AW),
    .MAX_VL (MV),
    .SEG_W  (SW),
    .REG_W  (RW),
    .ESZ_W  (ZW)
  ) u_vld_addr_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_base      (cmd_base),
    .cmd_esize     (cmd_esize),
    .cmd_stride    (cmd_stride),
    .cmd_strided   (cmd_strided),
    .cmd_indexed   (cmd_indexed),
    .cmd_idx       (cmd_idx),
    .cmd_nf        (cmd_nf),
    .cmd_len       (cmd_len),
    .cmd_dest      (cmd_dest),
    .cmd_pred_en   (cmd_pred_en),
    .cmd_pred_mask (cmd_pred_mask),
    .cmd_pred_inv  (cmd_pred_inv),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_reg       (req_reg),
    .req_elem      (req_elem),
    .done          (done)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog R10: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // Expected stream from the requirement formulas (R2, R3, R4, R5, R6, R7, R9).
  task automatic build();
    logic [AW-1:0] stp;
    logic [AW-1:0] off;
    bit            act;
    e_n = 0;
    stp = cmd_strided ? cmd_stride : AW'(cmd_esize);
    for (int i = 0; i < MV; i++) begin
      act = !cmd_pred_en || (cmd_pred_mask[i] ^ cmd_pred_inv);
      if ((i < int'(cmd_len)) && act) begin
        for (int j = 0; j <= int'(cmd_nf); j++) begin
          off = cmd_indexed ? cmd_idx[i*AW +: AW] : stp * AW'(i * (int'(cmd_nf) + 1));
          e_addr[e_n] = cmd_base + off + stp * AW'(j);
          e_reg[e_n]  = RW'(int'(cmd_dest) + j);
          e_elem[e_n] = EW'(i);
          e_n++;
        end
      end
    end
  endtask

  // Issues the current command and checks the whole stream.
  task automatic run(input string rq, input bit rnd, input bit poke);
    int            k;
    bit            lastp, stall, seen, exp_done;
    logic [AW-1:0] s_addr;
    logic [RW-1:0] s_reg;
    logic [EW-1:0] s_elem;
    build();
    @(negedge clk);
    cmd_valid = 1'b1;
    #1 chk(cmd_ready == 1'b1, "R1", "cmd_ready when idle", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid  = 1'b0;
    // R11: disturb inputs after capture.
    cmd_base   = ~cmd_base;
    cmd_idx    = ~cmd_idx;
    cmd_stride = cmd_stride + 32'h10;
    cmd_dest   = cmd_dest + 5'd7;
    cmd_pred_mask = ~cmd_pred_mask;
    k = 0; lastp = 0; stall = 0; seen = 0;
    s_addr = '0; s_reg = '0; s_elem = '0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (rnd) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready = lfsr[0];
      end else begin
        req_ready = 1'b1;
      end
      if (poke && c == 2) begin
        cmd_valid = 1'b1;
        cmd_len   = 4'd1;
      end
      if (poke && c == 4) cmd_valid = 1'b0;
      #1;
      if (poke && c == 3)
        chk(!cmd_ready, "R1", "cmd_ready while busy", 32'(cmd_ready), 32'd0);
      exp_done = (e_n == 0) ? (c == 1) : lastp;
      chk(done == exp_done, "R10", "done timing", 32'(done), 32'(exp_done));
      if (stall)
        chk(req_valid && req_addr == s_addr && req_reg == s_reg && req_elem == s_elem,
            "R8", "stalled request held", req_addr, s_addr);
      if (done) begin
        seen = 1;
        chk(cmd_ready == 1'b1, "R10", "cmd_ready with done", 32'(cmd_ready), 32'd1);
      end
      lastp = 0;
      stall = 0;
      if (req_valid && req_ready) begin
        if (k < e_n) begin
          chk(req_addr == e_addr[k], rq, "address (R11 capture)", req_addr, e_addr[k]);
          chk(req_reg == e_reg[k], "R5", "dest register", 32'(req_reg), 32'(e_reg[k]));
          chk(req_elem == e_elem[k], "R7", "element order", 32'(req_elem), 32'(e_elem[k]));
        end else begin
          chk(1'b0, "R7", "extra request", 32'(k), 32'(e_n));
        end
        lastp = (k == e_n - 1);
        k++;
      end else if (req_valid) begin
        stall  = 1;
        s_addr = req_addr;
        s_reg  = req_reg;
        s_elem = req_elem;
      end
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "R10", "done never seen", 32'd0, 32'd1);
    chk(k == e_n, "R7", "request count", 32'(k), 32'(e_n));
    req_ready = 1'b0;
    #1 chk(!done && cmd_ready && !req_valid, "R10", "idle after done",
           {29'd0, done, cmd_ready, req_valid}, 32'b010);
    @(negedge clk);
    #1 chk(!req_valid && cmd_ready, "R1", "no stray run",
           {30'd0, cmd_ready, req_valid}, 32'b10);
  endtask

  task automatic set_cmd(input logic [AW-1:0] base, input logic [ZW-1:0] esz,
                         input logic [AW-1:0] strd, input bit strided, input bit indexed,
                         input logic [SW-1:0] nf, input logic [VW-1:0] len,
                         input logic [RW-1:0] dest, input bit pen,
                         input logic [MV-1:0] mask, input bit inv);
    cmd_base = base; cmd_esize = esz; cmd_stride = strd;
    cmd_strided = strided; cmd_indexed = indexed; cmd_nf = nf;
    cmd_len = len; cmd_dest = dest; cmd_pred_en = pen;
    cmd_pred_mask = mask; cmd_pred_inv = inv;
  endtask

  task automatic t_reset();
    #1;
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk(req_valid == 1'b0, "R7", "reset req_valid", 32'(req_valid), 32'd0);
    chk(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);
  endtask

  task automatic t_unit();       // R2
    set_cmd(32'h0000_1000, 4'd4, 32'h0, 0, 0, 3'd0, 4'd5, 5'd3, 0, 8'h00, 0);
    run("R2", 0, 0);
  endtask

  task automatic t_const_busy(); // R3, R1
    set_cmd(32'h0000_2000, 4'd4, 32'h40, 1, 0, 3'd2, 4'd3, 5'd8, 0, 8'h00, 0);
    run("R3", 1, 1);
  endtask

  task automatic t_indexed();    // R4, R6
    cmd_idx = '0;
    cmd_idx[0*AW +: AW] = 32'h100; cmd_idx[1*AW +: AW] = 32'h8;
    cmd_idx[2*AW +: AW] = 32'h300; cmd_idx[3*AW +: AW] = 32'h24;
    cmd_idx[4*AW +: AW] = 32'h4;   cmd_idx[5*AW +: AW] = 32'hF00;
    set_cmd(32'h0001_0000, 4'd2, 32'h0, 0, 1, 3'd1, 4'd6, 5'd10, 1, 8'b0010_1101, 0);
    run("R4", 1, 0);
  endtask

  task automatic t_inverted();   // R6
    set_cmd(32'h0000_4000, 4'd8, 32'h0, 0, 0, 3'd1, 4'd8, 5'd0, 1, 8'b1100_1010, 1);
    run("R6", 0, 0);
  endtask

  task automatic t_none_active(); // R6, R10
    set_cmd(32'h0000_5000, 4'd4, 32'h0, 0, 0, 3'd2, 4'd8, 5'd1, 1, 8'h00, 0);
    run("R6", 0, 0);
  endtask

  task automatic t_zero_len();   // R7, R10
    set_cmd(32'h0000_6000, 4'd4, 32'h0, 0, 0, 3'd0, 4'd0, 5'd1, 0, 8'hFF, 0);
    run("R7", 0, 0);
  endtask

  task automatic t_wrap();       // R9, R5
    set_cmd(32'hFFFF_FFF0, 4'd4, 32'h10, 1, 0, 3'd3, 4'd2, 5'd30, 0, 8'h00, 0);
    run("R9", 1, 0);
  endtask

  task automatic t_full();       // R6 (mask ignored when disabled), R3
    set_cmd(32'h0000_8000, 4'd1, 32'hFFFF_FFFC, 1, 0, 3'd7, 4'd8, 5'd16, 0, 8'h00, 1);
    run("R3", 1, 0);
  endtask

  task automatic t_idx_stride(); // R4 with constant step
    cmd_idx = '0;
    cmd_idx[0*AW +: AW] = 32'h20; cmd_idx[1*AW +: AW] = 32'h0;
    cmd_idx[2*AW +: AW] = 32'h80; cmd_idx[3*AW +: AW] = 32'h40;
    set_cmd(32'h0002_0000, 4'd4, 32'h1000, 1, 1, 3'd2, 4'd4, 5'd4, 1, 8'hF0, 1);
    run("R4", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_unit();
    t_const_busy();
    t_indexed();
    t_inverted();
    t_none_active();
    t_zero_len();
    t_wrap();
    t_full();
    t_idx_stride();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule : vld_addr_gen_bench